// File: doc/BRIEF.md
# CPU Supervisor: Watchdog Reset and Heartbeat Interrupt

This block supervises a processor. A watchdog window counter has to be refreshed by a feed pulse before it runs out. If it is not refreshed, the block drives an active-low reset. The same reset goes to the processor and to a remote I/O driver board, and it stays low for a minimum hold length. A low supply flag or a pressed manual reset button also pulls reset low and keeps it there while the condition lasts. Once the cause is gone, the hold length runs again before reset is released.

A second counter advances once per processor bus clock tick, given as a one-cycle enable. Every `HB_PERIOD` ticks it raises a heartbeat interrupt request. The request stays up until software reads the switch port. The bus strobe of that read clears the request. With a 2 MHz bus tick and a period of 2048, the request recurs at about 976 Hz. At a 50 MHz clock, the default window is 250 ms and the default hold is 250 µs. All three lengths are parameters, so simulation can use short values.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst` is high, `cpu_rst_n`, `io_rst_n` and `hb_irq` are all 0.
- R2: After the last cycle with any reset cause (block reset, expiry, `supply_ok` low, `man_rst` high), reset stays low for exactly `HOLD_CYC` cycles and is high in the cycle after.
- R3: With reset released and no feed, reset stays high for exactly `TIMEOUT_CYC` cycles and then goes low.
- R4: A cycle with `feed` high restarts the window. Reset then stays high for the next `TIMEOUT_CYC` cycles. A feed held high on every cycle keeps reset high indefinitely.
- R5: `supply_ok` low drives reset low from the next cycle and keeps it low until `HOLD_CYC` cycles after `supply_ok` returns high.
- R6: `man_rst` high drives reset low from the next cycle and keeps it low until `HOLD_CYC` cycles after the button is released.
- R7: `io_rst_n` equals `cpu_rst_n` on every cycle.
- R8: `hb_irq` goes to 1 in the cycle after the `HB_PERIOD`-th `bus_tick` counted since block reset (and after every further `HB_PERIOD` ticks). Cycles with `bus_tick` low do not advance the count.
- R9: A cycle with `sw_rd_clr` high clears `hb_irq` from the next cycle. A clear while no request is pending leaves it at 0.
- R10: A period end that arrives while the request is still pending keeps `hb_irq` at 1 with no drop. A period end in the same cycle as a clear leaves `hb_irq` at 1.
- R11: `feed` has no effect while reset is low, so feeding during the hold does not shorten or lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_ok | input | 1 | High while the supply is good; low holds reset |
| man_rst | input | 1 | Manual reset button, active high |
| feed | input | 1 | Watchdog refresh pulse |
| bus_tick | input | 1 | One-cycle enable per processor bus clock |
| sw_rd_clr | input | 1 | Strobe of a switch-port read; clears the interrupt |
| cpu_rst_n | output | 1 | Active-low processor reset |
| io_rst_n | output | 1 | Active-low reset to the I/O board |
| hb_irq | output | 1 | Heartbeat interrupt request, active high |

## Verification
Each reset cause is registered once, so reset goes low one cycle after the cause. It comes back high `HOLD_CYC + 1` cycles after the last cause cycle. The interrupt request moves one cycle after the tick or the clear that changes it. The bench drives inputs and samples outputs on falling edges. It measures reset as the number of consecutive falling edges at one level, and compares each run length with `TIMEOUT_CYC`, `HOLD_CYC`, or a feed offset plus `TIMEOUT_CYC`. For the interrupt, it counts ticks itself and predicts the level one edge after each tick or clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Phase of the reset output.
    typedef enum logic [0:0] {
        PH_HOLD = 1'b0,
        PH_RUN  = 1'b1
    } rst_phase_e;

    // Causes that pull reset low; any set bit restarts the hold.
    typedef struct packed {
        logic expired;   // watchdog window ran out
        logic brownout;  // supply flag low
        logic button;    // manual reset pressed
    } rst_cause_t;

    // Counter width for a count of n states, at least one bit.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdt_window.sv
module wdt_window
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic feed,
    output logic expired
);
    localparam int unsigned CW = cnt_bits(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] age;
    logic          at_limit;

    assign at_limit = (age == LAST);
    assign expired  = run && !feed && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !run || feed) begin
            age <= '0;
        end else if (!at_limit) begin
            age <= age + 1'b1;
        end
    end

    // R3: the age never passes the end of the window
    p_age_bound_r3: assert property (@(posedge clk) disable iff (rst)
        age <= LAST);

    // R4: a feed while running restarts the window
    p_feed_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (run && feed) |=> (age == '0));

    // R11: the window is idle while reset is held
    p_idle_in_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !run |=> (age == '0));

endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
    import wdt_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 12_500
) (
    input  logic       clk,
    input  logic       rst,
    input  rst_cause_t cause,
    output logic       run,
    output logic       cpu_rst_n,
    output logic       io_rst_n
);
    localparam int unsigned CW = cnt_bits(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    rst_phase_e    phase, phase_nxt;
    logic [CW-1:0] hold_cnt, hold_nxt;
    logic          trigger;

    assign trigger = |cause;
    assign run     = (phase == PH_RUN);

    always_comb begin
        phase_nxt = phase;
        hold_nxt  = hold_cnt;
        unique case (phase)
            PH_RUN: begin
                if (trigger) begin
                    phase_nxt = PH_HOLD;
                    hold_nxt  = '0;
                end
            end
            PH_HOLD: begin
                if (trigger) begin
                    hold_nxt = '0;
                end else if (hold_cnt == LAST) begin
                    phase_nxt = PH_RUN;
                end else begin
                    hold_nxt = hold_cnt + 1'b1;
                end
            end
            default: begin
                phase_nxt = PH_HOLD;
                hold_nxt  = '0;
            end
        endcase
    end

    // The processor and the off-board driver each get their own flop.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_HOLD;
            hold_cnt  <= '0;
            cpu_rst_n <= 1'b0;
            io_rst_n  <= 1'b0;
        end else begin
            phase     <= phase_nxt;
            hold_cnt  <= hold_nxt;
            cpu_rst_n <= (phase_nxt == PH_RUN);
            io_rst_n  <= (phase_nxt == PH_RUN);
        end
    end

    // R2: the hold counter stays inside the hold length
    p_hold_bound_r2: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= LAST);

    // R2: release only after a full, cause-free hold
    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst_n) |-> ($past(hold_cnt) == LAST && !$past(trigger)));

    // R5: a low supply pulls reset low on the next cycle
    p_brownout_r5: assert property (@(posedge clk) disable iff (rst)
        cause.brownout |=> !cpu_rst_n);

    // R6: the button pulls reset low on the next cycle
    p_button_r6: assert property (@(posedge clk) disable iff (rst)
        cause.button |=> !cpu_rst_n);

    // R7: both reset copies agree
    p_copies_agree_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_n == io_rst_n);

endmodule

// File: rtl/wdt_heartbeat.sv
module wdt_heartbeat
    import wdt_pkg::*;
#(
    parameter int unsigned HB_PERIOD = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    output logic irq
);
    localparam int unsigned CW = cnt_bits(HB_PERIOD);
    localparam logic [CW-1:0] LAST = CW'(HB_PERIOD - 1);

    logic [CW-1:0] beat;
    logic          wrap;

    assign wrap = tick && (beat == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
            irq  <= 1'b0;
        end else begin
            if (wrap) begin
                beat <= '0;
            end else if (tick) begin
                beat <= beat + 1'b1;
            end
            // a period end wins over a clear in the same cycle
            if (wrap) begin
                irq <= 1'b1;
            end else if (clr) begin
                irq <= 1'b0;
            end
        end
    end

    // R8: each period end raises the request
    p_period_sets_r8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> irq);

    // R8: the count holds without a tick
    p_beat_stall_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(beat));

    // R9: a clear with no period end drops the request
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !wrap) |=> !irq);

    // R10: a pending request is held until a clear
    p_no_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 12_500_000,
    parameter int unsigned HOLD_CYC    = 12_500,
    parameter int unsigned HB_PERIOD   = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic man_rst,
    input  logic feed,
    input  logic bus_tick,
    input  logic sw_rd_clr,
    output logic cpu_rst_n,
    output logic io_rst_n,
    output logic hb_irq
);
    rst_cause_t cause;
    logic       run;
    logic       expired;

    assign cause.expired  = expired;
    assign cause.brownout = !supply_ok;
    assign cause.button   = man_rst;

    wdt_window #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_window (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .feed    (feed),
        .expired (expired)
    );

    wdt_rst_ctrl #(
        .HOLD_CYC (HOLD_CYC)
    ) u_rst_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cause     (cause),
        .run       (run),
        .cpu_rst_n (cpu_rst_n),
        .io_rst_n  (io_rst_n)
    );

    wdt_heartbeat #(
        .HB_PERIOD (HB_PERIOD)
    ) u_heartbeat (
        .clk  (clk),
        .rst  (rst),
        .tick (bus_tick),
        .clr  (sw_rd_clr),
        .irq  (hb_irq)
    );

    // R3: an expired window pulls reset low on the next cycle
    p_expire_r3: assert property (@(posedge clk) disable iff (rst)
        expired |=> !cpu_rst_n);

    // R1: the reset outputs are low in the cycle after a block reset
    p_block_reset_r1: assert property (@(posedge clk)
        rst |=> (!cpu_rst_n && !io_rst_n && !hb_irq));

endmodule

// File: tb/tb_wdt_supervisor.sv
module tb_wdt_supervisor;
    localparam int T  = 20;
    localparam int H  = 6;
    localparam int HB = 8;

    logic clk = 1'b0;
    logic rst, supply_ok, man_rst, feed, bus_tick, sw_rd_clr;
    logic cpu_rst_n, io_rst_n, hb_irq;

    int checks = 0;
    int errors = 0;
    int mismatch = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_supervisor #(
        .TIMEOUT_CYC (T),
        .HOLD_CYC    (H),
        .HB_PERIOD   (HB)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .man_rst   (man_rst),
        .feed      (feed),
        .bus_tick  (bus_tick),
        .sw_rd_clr (sw_rd_clr),
        .cpu_rst_n (cpu_rst_n),
        .io_rst_n  (io_rst_n),
        .hb_irq    (hb_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Number of consecutive falling edges, starting with the current one,
    // on which cpu_rst_n equals lvl.
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (cpu_rst_n == lvl && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_tick();
        bus_tick = 1'b1;
        @(negedge clk);
        bus_tick = 1'b0;
    endtask

    task automatic pulse_clr();
        sw_rd_clr = 1'b1;
        @(negedge clk);
        sw_rd_clr = 1'b0;
    endtask

    // R7: the two reset copies are compared on every falling edge
    always @(negedge clk) begin
        if (cpu_rst_n !== io_rst_n) mismatch++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; supply_ok = 1'b1; man_rst = 1'b0;
        feed = 1'b0; bus_tick = 1'b0; sw_rd_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk(cpu_rst_n == 1'b0, "R1 cpu_rst_n", cpu_rst_n, 0);
        chk(io_rst_n == 1'b0, "R1 io_rst_n", io_rst_n, 0);
        chk(hb_irq == 1'b0, "R1 hb_irq", hb_irq, 0);

        // R2: release after the block reset
        rst = 1'b0;
        run_len(1'b0, n);
        chk(n == H, "R2 hold after block reset", n, H);

        // R3: unfed window, then hold after expiry
        run_len(1'b1, n);
        chk(n == T, "R3 window length", n, T);
        run_len(1'b0, n);
        chk(n == H, "R2 hold after expiry", n, H);

        // R4: feed at every offset inside the window
        for (int k = 0; k < T; k++) begin
            repeat (k) @(negedge clk);
            feed = 1'b1;
            @(negedge clk);
            feed = 1'b0;
            run_len(1'b1, n);
            chk(n == T, $sformatf("R4 feed at offset %0d", k), n, T);
            run_len(1'b0, n);
            chk(n == H, "R2 hold after fed expiry", n, H);
        end

        // R11: feed held through the hold does not change it
        run_len(1'b1, n);
        chk(n == T, "R3 window before R11", n, T);
        feed = 1'b1;
        run_len(1'b0, n);
        chk(n == H, "R11 hold with feed", n, H);

        // R4: a continuous feed keeps reset high
        n = 0;
        for (int i = 0; i < 3 * T; i++) begin
            if (!cpu_rst_n) n++;
            @(negedge clk);
        end
        chk(n == 0, "R4 continuous feed low edges", n, 0);

        // R5: supply low for several lengths
        for (int len = 1; len <= 4; len++) begin
            supply_ok = 1'b0;
            @(negedge clk);
            chk(cpu_rst_n == 1'b0, "R5 low after supply drop", cpu_rst_n, 0);
            repeat (len - 1) @(negedge clk);
            supply_ok = 1'b1;
            run_len(1'b0, n);
            chk(n == H, $sformatf("R5 hold after supply low %0d", len), n, H);
        end

        // R6: button pressed for several lengths
        for (int len = 1; len <= 4; len++) begin
            man_rst = 1'b1;
            @(negedge clk);
            chk(cpu_rst_n == 1'b0, "R6 low after button", cpu_rst_n, 0);
            repeat (len - 1) @(negedge clk);
            man_rst = 1'b0;
            run_len(1'b0, n);
            chk(n == H, $sformatf("R6 hold after button %0d", len), n, H);
        end

        // R8/R9: periods with different tick spacings, cleared each time
        chk(hb_irq == 1'b0, "R8 idle before ticks", hb_irq, 0);
        for (int g = 1; g <= 3; g++) begin
            for (int i = 1; i <= HB; i++) begin
                pulse_tick();
                chk(hb_irq == (i == HB), $sformatf("R8 gap %0d tick %0d", g, i),
                    hb_irq, (i == HB));
                repeat (g - 1) @(negedge clk);
            end
            repeat (5) @(negedge clk);
            chk(hb_irq == 1'b1, "R8 held without ticks", hb_irq, 1);
            pulse_clr();
            chk(hb_irq == 1'b0, "R9 clear", hb_irq, 0);
        end
        pulse_clr();
        chk(hb_irq == 1'b0, "R9 clear with nothing pending", hb_irq, 0);

        // R10: a second period end while pending
        for (int i = 0; i < HB; i++) pulse_tick();
        chk(hb_irq == 1'b1, "R10 first fire", hb_irq, 1);
        for (int i = 1; i <= HB; i++) begin
            pulse_tick();
            chk(hb_irq == 1'b1, $sformatf("R10 pending at tick %0d", i), hb_irq, 1);
        end
        pulse_clr();
        chk(hb_irq == 1'b0, "R9 clear after refire", hb_irq, 0);

        // R10: period end and clear in the same cycle
        for (int i = 0; i < HB - 1; i++) pulse_tick();
        chk(hb_irq == 1'b0, "R8 one tick short", hb_irq, 0);
        bus_tick = 1'b1;
        sw_rd_clr = 1'b1;
        @(negedge clk);
        bus_tick = 1'b0;
        sw_rd_clr = 1'b0;
        chk(hb_irq == 1'b1, "R10 set wins over clear", hb_irq, 1);
        pulse_clr();
        chk(hb_irq == 1'b0, "R9 final clear", hb_irq, 0);

        chk(mismatch == 0, "R7 reset copies differ", mismatch, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule